// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading translation entries from memory. A request carries the virtual address and two attributes: whether the access is a write, and whether it comes from user mode. The walker reads one entry from a 1024-entry directory, whose physical base address comes from a base-register input. It then reads one entry from the 1024-entry table page that the directory entry points to. The reply is either the physical address or a fault with a cause and the level where the fault was found.

Two other modes are available. A directory entry can map a 4 MB region on its own when large pages are enabled, and in that case the second read is not made. When paging is off, the address passes through unchanged and no memory is read. Only one walk is in progress at a time. The memory port uses a request/valid pair and may take any number of cycles to answer.

Top module: `pt_walker`

## Requirements
- R1: When `paging_on` is low at acceptance, the reply comes in the cycle after acceptance with `rsp_paddr` equal to the virtual address and `rsp_fault` low, and `mem_req` is never raised.
- R2: The first read of a walk targets `base + 4*va[31:22]`, where `base` is the value of `root_base` sampled when the request is accepted. Later changes to `root_base` do not affect that walk.
- R3: The second read targets `{pde[31:12],12'h000} + 4*va[21:12]`, where `pde` is the directory entry returned by the first read.
- R4: A successful two-level walk returns `{pte[31:12], va[11:0]}`. For example, va 0x80100000 with a table entry whose page number is 0x00100 gives 0x00100000.
- R5: An entry with bit 0 (present) clear ends the walk with `rsp_fault` high and `rsp_cause`=0 (not present). `rsp_level` is 0 for the directory and 1 for the table.
- R6: A user access (`req_user`=1) to an entry with bit 2 (user) clear, at either level, ends the walk with `rsp_cause`=1 (protection) and the level of that entry.
- R7: A write (`req_write`=1) to an entry with bit 1 (writable) clear, at either level, ends the walk with `rsp_cause`=1 and the level of that entry.
- R8: When `big_pages_on` is high at acceptance and a present, permitted directory entry has bit 7 set, the reply is `{pde[31:22], va[21:0]}` after exactly one memory read.
- R9: When `big_pages_on` is low at acceptance, bit 7 of a directory entry is ignored and the walk reads the table.
- R10: `req_ready` is low from acceptance until the reply. While `mem_req` is high and `mem_valid` is low, `mem_req` and `mem_addr` stay unchanged.
- R11: `rsp_valid` is a single-cycle pulse for each accepted request, and `rsp_paddr` is 0 when a fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| root_base | input | 32 | Physical address of the directory |
| paging_on | input | 1 | Translation enabled; when low, addresses pass through |
| big_pages_on | input | 1 | Allows directory entries with bit 7 set to map 4 MB |
| rsp_valid | output | 1 | Reply pulse |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 1 | 0 = not present, 1 = protection |
| rsp_level | output | 1 | 0 = directory, 1 = table |
| mem_req | output | 1 | Memory read request, held until data returns |
| mem_addr | output | 32 | Physical address of the entry to read |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 32 | Entry returned by memory |

## Verification
The hardest case to reach is a fault at the table level, because the directory entry must first pass the present check, the permission check and the large-page check. The bench reaches it, together with every other outcome, by sweeping all flag combinations of both levels against every write, user and large-page-enable setting. The entries for each step are built fresh in a model memory. Each walk also runs with a different memory latency, and `root_base` is corrupted right after acceptance, so that the rules for holding the address and for sampling the base are exercised on every walk.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] root_base,
  input  logic        paging_on,
  input  logic        big_pages_on,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        rsp_cause,
  output logic        rsp_level,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_valid,
  input  logic [31:0] mem_data
);
  localparam int FP = 0;
  localparam int FW = 1;
  localparam int FU = 2;
  localparam int FBIG = 7;

  typedef enum logic [1:0] {IDLE, RD_DIR, RD_TBL, REPLY} st_t;
  st_t st;

  logic [31:0] va, base, pde;
  logic wr, usr, big_ok, deny;

  assign req_ready = (st == IDLE);
  assign mem_req   = (st == RD_DIR) || (st == RD_TBL);
  assign rsp_valid = (st == REPLY);
  assign mem_addr  = (st == RD_TBL) ? {pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00}
                                    : base + {20'h0, va[31:22], 2'b00};
  assign deny = (usr && !mem_data[FU]) || (wr && !mem_data[FW]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      va <= '0;
      base <= '0;
      pde <= '0;
      wr <= 1'b0;
      usr <= 1'b0;
      big_ok <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= 1'b0;
      rsp_level <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va <= req_vaddr;
          base <= root_base;
          wr <= req_write;
          usr <= req_user;
          big_ok <= big_pages_on;
          rsp_fault <= 1'b0;
          rsp_cause <= 1'b0;
          rsp_level <= 1'b0;
          if (!paging_on) begin
            rsp_paddr <= req_vaddr;
            st <= REPLY;
          end else begin
            rsp_paddr <= '0;
            st <= RD_DIR;
          end
        end
        RD_DIR: if (mem_valid) begin
          st <= REPLY;
          if (!mem_data[FP]) begin
            rsp_fault <= 1'b1;
          end else if (deny) begin
            rsp_fault <= 1'b1;
            rsp_cause <= 1'b1;
          end else if (big_ok && mem_data[FBIG]) begin
            rsp_paddr <= {mem_data[31:22], va[21:0]};
          end else begin
            pde <= mem_data;
            st <= RD_TBL;
          end
        end
        RD_TBL: if (mem_valid) begin
          st <= REPLY;
          rsp_level <= 1'b1;
          if (!mem_data[FP]) begin
            rsp_fault <= 1'b1;
          end else if (deny) begin
            rsp_fault <= 1'b1;
            rsp_cause <= 1'b1;
          end else begin
            rsp_paddr <= {mem_data[31:12], va[11:0]};
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !paging_on) |=>
      (rsp_valid && !rsp_fault && !mem_req && rsp_paddr == $past(req_vaddr)));

  // R5
  absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && !mem_data[0]) |=> (rsp_valid && rsp_fault && !rsp_cause));

  // R10
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && paging_on) |=> !req_ready);

  // R11
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11
  zero_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0, root_base = '0;
  logic paging_on = 1'b0, big_pages_on = 1'b0;
  logic req_ready, rsp_valid, rsp_fault, rsp_cause, rsp_level, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic mem_valid = 1'b0;
  logic [31:0] mem_data = '0;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .root_base(root_base), .paging_on(paging_on), .big_pages_on(big_pages_on),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_level(rsp_level), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  int lat = 0, wcnt = 0, nreads = 0;
  logic [31:0] a0, a1;
  logic [31:0] mem [logic [31:0]];

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_data = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        mem_valid = 1'b1;
        if (nreads == 0) a0 = mem_addr; else a1 = mem_addr;
        nreads++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xlat(input logic [31:0] va, input bit wr, input bit us,
                      input logic [31:0] base, input bit pg, input bit lg);
    bit busy_ok = 1'b1;
    int n = 0;
    @(negedge clk);
    nreads = 0;
    req_vaddr = va; req_write = wr; req_user = us;
    root_base = base; paging_on = pg; big_pages_on = lg;
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    root_base = ~base;
    big_pages_on = ~lg;
    paging_on = ~pg;
    @(negedge clk);
    while (!rsp_valid && n < 100) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(busy_ok && rsp_valid, "R10 busy/reply", {31'h0, busy_ok}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0, "R11 reset state",
        {29'h0, req_ready, rsp_valid, mem_req}, 32'h4);
    rst_n = 1'b1;

    // R1: pass-through
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'h9E37_79B9 * (i + 1);
      xlat(v, i[0], i[1], 32'h0000_5000, 1'b0, i[2]);
      chk(!rsp_fault && rsp_paddr == v, "R1 paddr", rsp_paddr, v);
      chk(nreads == 0, "R1 no reads", nreads, 0);
      @(negedge clk);
      chk(!rsp_valid, "R11 pulse", {31'h0, rsp_valid}, 0);
    end

    // R4 worked example
    mem.delete();
    mem[32'h0001_0800] = 32'h0002_0007;
    mem[32'h0002_0400] = 32'h0010_0007;
    lat = 2;
    xlat(32'h8010_0000, 1'b1, 1'b1, 32'h0001_0000, 1'b1, 1'b0);
    chk(!rsp_fault && rsp_paddr == 32'h0010_0000, "R4 example", rsp_paddr, 32'h0010_0000);

    // sweep of flags, modes and access kinds
    for (int k = 0; k < 1024; k++) begin
      logic [2:0] df, tf;
      logic d7, wr, us, lg, ef, ec, el;
      logic [31:0] va, base, tpg, pde, pte, ep, ea0, ea1;
      int er;
      df = k[2:0]; d7 = k[3]; tf = k[6:4]; wr = k[7]; us = k[8]; lg = k[9];
      va = {10'((k * 37) % 1024), 10'((k * 91 + 5) % 1024), 12'((k * 13) % 4096)};
      base = 32'h0040_0000 + 32'(k) * 32'h1000;
      tpg = 32'h1000_0000 + 32'(k) * 32'h1000;
      pde = {tpg[31:12], 4'h0, d7, 4'h0, df};
      pte = {20'((k * 977 + 17) % 1048576), 9'h0, tf};
      mem.delete();
      ea0 = base + {20'h0, va[31:22], 2'b00};
      ea1 = tpg + {20'h0, va[21:12], 2'b00};
      mem[ea0] = pde;
      mem[ea1] = pte;
      lat = k % 4;
      ef = 1; ec = 0; el = 0; ep = 0; er = 1;
      if (!df[0]) begin ec = 0; end
      else if ((us && !df[2]) || (wr && !df[1])) ec = 1;
      else if (lg && d7) begin ef = 0; ep = {pde[31:22], va[21:0]}; end
      else begin
        er = 2; el = 1;
        if (!tf[0]) ec = 0;
        else if ((us && !tf[2]) || (wr && !tf[1])) ec = 1;
        else begin ef = 0; ep = {pte[31:12], va[11:0]}; end
      end
      xlat(va, wr, us, base, 1'b1, lg);
      chk(rsp_fault == ef, "R5/R6/R7 fault flag", {31'h0, rsp_fault}, {31'h0, ef});
      if (ef) begin
        chk(rsp_cause == ec && rsp_level == el, ec ? "R6/R7 cause+level" : "R5 cause+level",
            {30'h0, rsp_cause, rsp_level}, {30'h0, ec, el});
        chk(rsp_paddr == 0, "R11 zero paddr", rsp_paddr, 0);
      end else begin
        chk(rsp_paddr == ep, (er == 1) ? "R8 large paddr" : "R4 paddr", rsp_paddr, ep);
      end
      chk(nreads == er, (d7 && !lg) ? "R9 read count" : "R8 read count", nreads, er);
      chk(a0 == ea0, "R2 dir addr", a0, ea0);
      if (er == 2) chk(a1 == ea1, "R3 table addr", a1, ea1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule